// File: doc/BRIEF.md
# I2C Master Interrupt Status and Vector Controller

This block sits beside an I2C master bus engine and turns its single-cycle event strobes into sticky status flags. Software clears a flag by writing a one to its position in the status register. A per-event enable mask selects which flags drive the interrupt line. The mask can be written whole, or changed one bit at a time through a set port and a clear port, so that an interrupt handler never has to do a read-modify-write that could race with other code.

For software written against the older single-vector model, a read-only vector register reports the most urgent pending bus event as a small code. Reading the vector clears the event it returns. The status register also shows a live bus-busy bit taken straight from the bus engine, and a wake-enable register holds the mask used by the power controller.

The register port uses one-cycle read and write strobes with a 3-bit address. Read data is combinational from the address while the read strobe is high. A side effect of a read or a write takes hold at the rising edge where the strobe is sampled.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: Each event strobe `evt_i[b]` for b in {0 arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as target, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain} sets status bit b at the next rising edge. The bit stays set until it is cleared.
- R2: A write to the status register (address 0) clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R3: If an event strobe and a clear (by status write or by vector read) hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 12 reads the live `bus_busy_i` input in the same cycle. `evt_i[12]` and status writes have no effect on it.
- R5: Status bits 5, 6, 7 and 15 always read 0.
- R6: The enable register (address 1) can be written whole. Only bits 0–4, 13 and 14 are kept; all other enable bits read 0.
- R7: A write to address 2 sets the enable bits where the data is 1. A write to address 3 clears the enable bits where the data is 1. Neither write changes any other enable bit. Reads of address 2 or 3 return the enable register.
- R8: `irq_o` is registered. It is high in the cycle after any status bit and its enable bit are both 1, and low in the cycle after none are. It is 0 out of reset.
- R9: A read of address 4 returns the vector code in bits [2:0], with all upper bits 0. The codes are: 0 none, 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready. The lowest nonzero pending code is reported first, and the enable mask is not consulted.
- R10: A vector read clears the status bit it reported, at the same rising edge. Other status bits are unchanged.
- R11: The wake-enable register (address 5) is read/write. Only bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14 are kept.
- R12: After reset, the status, enable and wake-enable registers and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | One-cycle event strobes from the bus engine, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level from the bus engine |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a vector read has a side effect) |
| reg_addr_i | input | 3 | Register address: 0 status, 1 enable, 2 enable-set, 3 enable-clear, 4 vector, 5 wake-enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while `reg_rd_i` is high, 0 otherwise |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples it one time unit after it raises the read strobe at a falling edge. An event, write or vector-read side effect becomes visible in a status or enable read one cycle after its strobe, at the falling edge that follows the sampling rising edge. The interrupt line sits one register further down. The bench therefore checks that `irq_o` is still low at the first falling edge after the event has been latched, and high at the next one. Clearing an enable is checked the same way for the falling edge of `irq_o`.

// File: rtl/i2c_irq_pkg.sv
// Package: shared widths, register addresses and bit masks for the
// interrupt status controller. Assumes a 16-bit register file.
package i2c_irq_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int VEC_SRC = 5;                 // events reported through the vector
    localparam int BUSY_POS = 12;

    localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_ENSET = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ENCLR = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_VEC   = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_WAKE  = 3'd5;

    // latched event positions (bus-busy excluded: it is live)
    localparam logic [REG_W-1:0] STAT_MASK = 16'h6F1F;
    // positions that can raise the interrupt line
    localparam logic [REG_W-1:0] EN_MASK   = 16'h601F;
    // positions kept in the wake-enable register
    localparam logic [REG_W-1:0] WAKE_MASK = 16'h636F;
endpackage

// File: rtl/irq_status_bank.sv
// Sticky status flags. Each position allowed by LATCH_MASK latches its
// event strobe and holds it until a clear request. A set in the same
// cycle as a clear wins. Assumes strobes are synchronous to clk.
module irq_status_bank #(
    parameter int                 W          = 16,
    parameter logic [W-1:0]       LATCH_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] stat_nxt;

    // per-bit next state; positions outside the mask are tied low
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (LATCH_MASK[g]) begin : g_live
            assign stat_nxt[g] = set_i[g] | (stat_q[g] & ~clr_i[g]);
        end else begin : g_dead
            assign stat_nxt[g] = 1'b0;
        end
    end

    // flag register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_enable_mask.sv
// Interrupt enable mask with three write forms: whole-word load,
// set-where-one and clear-where-one. Only KEEP_MASK positions exist.
// Assumes at most one of the three write strobes per cycle.
module irq_enable_mask #(
    parameter int           W         = 16,
    parameter logic [W-1:0] KEEP_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;
    logic [W-1:0] en_nxt;

    // choose the update form
    always_comb begin
        en_nxt = en_q;
        if (load_i)     en_nxt = data_i;
        else if (set_i) en_nxt = en_q | data_i;
        else if (clr_i) en_nxt = en_q & ~data_i;
    end

    // mask register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt & KEEP_MASK;
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_vector_enc.sv
// Priority encoder for the legacy vector: lowest pending source index
// wins and is reported as index+1; 0 means nothing pending. Also gives
// a one-hot of the reported source so it can be cleared.
module irq_vector_enc #(
    parameter int N_SRC  = 5,
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]  pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N_SRC-1:0]  hit_o
);
    // scan from high to low so the lowest index is assigned last
    always_comb begin
        code_o = '0;
        hit_o  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o = CODE_W'(i + 1);
                hit_o  = N_SRC'(1) << i;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_ctrl.sv
// Top: interrupt status, enable and vector registers for an I2C master.
// Event strobes become sticky flags; enabled flags drive a registered
// interrupt; a vector read reports and clears the most urgent bus event.
// Assumes one-cycle read/write strobes and no simultaneous read+write.
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              bus_busy_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam int CODE_W = $clog2(VEC_SRC + 1);

    logic [REG_W-1:0]   stat_q;
    logic [REG_W-1:0]   en_q;
    logic [REG_W-1:0]   wake_q;
    logic [REG_W-1:0]   stat_clr;
    logic [CODE_W-1:0]  vec_code;
    logic [VEC_SRC-1:0] vec_hit;
    logic               vec_rd;
    logic               irq_q;

    assign vec_rd = reg_rd_i && (reg_addr_i == ADDR_VEC);

    irq_vector_enc #(.N_SRC(VEC_SRC), .CODE_W(CODE_W)) u_vec (
        .pend_i (stat_q[VEC_SRC-1:0]),
        .code_o (vec_code),
        .hit_o  (vec_hit)
    );

    // merge the clear sources: status write-one and vector read
    always_comb begin
        stat_clr = '0;
        if (reg_wr_i && (reg_addr_i == ADDR_STAT)) stat_clr = reg_wdata_i;
        if (vec_rd) stat_clr[VEC_SRC-1:0] = stat_clr[VEC_SRC-1:0] | vec_hit;
    end

    irq_status_bank #(.W(REG_W), .LATCH_MASK(STAT_MASK)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    irq_enable_mask #(.W(REG_W), .KEEP_MASK(EN_MASK)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_wr_i && (reg_addr_i == ADDR_EN)),
        .set_i  (reg_wr_i && (reg_addr_i == ADDR_ENSET)),
        .clr_i  (reg_wr_i && (reg_addr_i == ADDR_ENCLR)),
        .data_i (reg_wdata_i),
        .en_o   (en_q)
    );

    // wake-enable register
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= '0;
        else if (reg_wr_i && (reg_addr_i == ADDR_WAKE))
            wake_q <= reg_wdata_i & WAKE_MASK;
    end

    // registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & en_q);
    end

    assign irq_o = irq_q;

    // read data mux; status shows the live bus-busy level
    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i) begin
            case (reg_addr_i)
                ADDR_STAT: begin
                    reg_rdata_o = stat_q;
                    reg_rdata_o[BUSY_POS] = bus_busy_i;
                end
                ADDR_EN, ADDR_ENSET, ADDR_ENCLR: reg_rdata_o = en_q;
                ADDR_VEC:  reg_rdata_o = REG_W'(vec_code);
                ADDR_WAKE: reg_rdata_o = wake_q;
                default:   reg_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt controller, bound to
// the top module. Observes ports plus the status and enable registers.
module i2c_irq_ctrl_chk
    import i2c_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic              irq_o,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  en_q
);
    p_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & STAT_MASK)) |=>
        ((stat_q & $past(evt_i & STAT_MASK)) == $past(evt_i & STAT_MASK)));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_STAT) |=>
        ((stat_q & $past(reg_wdata_i & ~evt_i)) == '0));

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_STAT && |(evt_i & reg_wdata_i & STAT_MASK)) |=>
        ((stat_q & $past(evt_i & reg_wdata_i & STAT_MASK)) == $past(evt_i & reg_wdata_i & STAT_MASK)));

    p_dead_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~STAT_MASK) == '0);

    p_en_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_ENCLR) |=>
        ((en_q & $past(reg_wdata_i)) == '0));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & en_q)) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & en_q)) |=> !irq_o);

    p_vec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_VEC && stat_q[0] && !evt_i[0]) |=> !stat_q[0]);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .stat_q      (stat_q),
    .en_q        (en_q)
);

// File: tb/i2c_irq_ctrl_tb_top.sv
// Directed bench for the interrupt controller: one task per scenario.
// Inputs change at falling edges; combinational reads are sampled 1
// time unit after the read strobe is raised.
module i2c_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_irq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .bus_busy_i (bus_busy_i),
        .reg_wr_i (reg_wr_i), .reg_rd_i (reg_rd_i), .reg_addr_i (reg_addr_i),
        .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o), .irq_o (irq_o)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        reg_rd_i = 1'b1; reg_addr_i = a;
        #1 d = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic pulse(logic [15:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R12 irq", {15'd0, irq_o}, 16'h0);
        rd(3'd0, d); check("R12 status", d, 16'h0000);
        rd(3'd1, d); check("R12 enable", d, 16'h0000);
        rd(3'd5, d); check("R12 wake", d, 16'h0000);
        rd(3'd4, d); check("R9 vector idle", d, 16'h0000);
    endtask

    task automatic t_latch();
        logic [15:0] d;
        pulse(16'hFFFF);
        rd(3'd0, d); check("R1 R5 all events latched", d, 16'h6F1F);
        @(negedge clk);
        rd(3'd0, d); check("R1 sticky", d, 16'h6F1F);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, d); check("R2 clear all", d, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        pulse(16'h0F00);
        wr(3'd0, 16'h0500);
        rd(3'd0, d); check("R2 partial clear", d, 16'h0A00);
        wr(3'd0, 16'h0000);
        rd(3'd0, d); check("R2 zero write no effect", d, 16'h0A00);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        pulse(16'h000A);
        evt_i = 16'h0008; reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 16'h000A;
        @(negedge clk);
        evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        rd(3'd0, d); check("R3 set beats clear", d, 16'h0008);
        // vector read of bit 3 while its event fires again
        pulse(16'h0000);
        evt_i = 16'h0008;
        rd(3'd4, d); check("R9 vector code 4", d, 16'h0004);
        evt_i = '0;
        rd(3'd0, d); check("R3 set beats vector clear", d, 16'h0008);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_busy();
        logic [15:0] d;
        bus_busy_i = 1'b1;
        rd(3'd0, d); check("R4 busy live high", d, 16'h1000);
        bus_busy_i = 1'b0;
        rd(3'd0, d); check("R4 busy live low", d, 16'h0000);
        pulse(16'h1000);
        rd(3'd0, d); check("R4 busy strobe ignored", d, 16'h0000);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        wr(3'd1, 16'hFFFF);
        rd(3'd1, d); check("R6 enable mask", d, 16'h601F);
        wr(3'd3, 16'h0003);
        rd(3'd3, d); check("R7 clear port", d, 16'h601C);
        wr(3'd2, 16'h0001);
        rd(3'd2, d); check("R7 set port", d, 16'h601D);
        wr(3'd1, 16'h0000);
        rd(3'd1, d); check("R6 enable cleared", d, 16'h0000);
    endtask

    task automatic t_irq();
        pulse(16'h0100);
        wr(3'd1, 16'hFFFF);
        @(negedge clk);
        check("R8 non-enableable event no irq", {15'd0, irq_o}, 16'h0);
        wr(3'd1, 16'h0002);
        pulse(16'h0002);
        check("R8 irq registered delay", {15'd0, irq_o}, 16'h0);
        @(negedge clk);
        check("R8 irq high", {15'd0, irq_o}, 16'h1);
        wr(3'd3, 16'h0002);
        check("R8 irq still high one cycle", {15'd0, irq_o}, 16'h1);
        @(negedge clk);
        check("R8 irq low after disable", {15'd0, irq_o}, 16'h0);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_vector();
        logic [15:0] d;
        pulse(16'h0216);
        rd(3'd4, d); check("R9 lowest first", d, 16'h0002);
        rd(3'd4, d); check("R9 next code", d, 16'h0003);
        rd(3'd0, d); check("R10 only reported bits cleared", d, 16'h0210);
        rd(3'd4, d); check("R9 transmit code", d, 16'h0005);
        rd(3'd4, d); check("R9 vector none", d, 16'h0000);
        rd(3'd0, d); check("R10 non-vector bit kept", d, 16'h0200);
        pulse(16'h0001);
        rd(3'd4, d); check("R9 arbitration code", d, 16'h0001);
        rd(3'd0, d); check("R10 arbitration cleared", d, 16'h0200);
        wr(3'd0, 16'hFFFF);
    endtask

    task automatic t_wake();
        logic [15:0] d;
        wr(3'd5, 16'hFFFF);
        rd(3'd5, d); check("R11 wake mask", d, 16'h636F);
        wr(3'd5, 16'h0021);
        rd(3'd5, d); check("R11 wake write", d, 16'h0021);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_w1c();
        t_set_wins();
        t_busy();
        t_enable();
        t_irq();
        t_vector();
        t_wake();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule